// File: doc/BRIEF.md
# Seconds Timekeeper Register File

This block keeps wall-clock time as a 32-bit count of seconds behind a small memory-mapped register port. An external timebase delivers one single-cycle pulse per second, and the block advances its seconds counter on each pulse. When software programs a new time, the value is staged rather than applied at once: it lands in the counter on the next seconds pulse. Until then, the current-time register still shows the old running value. Software can tell that a load is still waiting because the seconds status bit has not been set again since it cleared it.

A 32-bit alarm value is compared against the counter whenever a pulse moves it. Two interrupt sources, a per-second event and an alarm match, each have a sticky status bit that is cleared by writing 1. Each source is switched on and off through separate write-1 enable and disable addresses, and its state can be read back. The block also holds a calibration word for the external tick generator and two control bits that drive the oscillator enable and the battery switch-over enable. The tick generator's current fractional count is readable through the same port.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, every readable register returns 0, both interrupt outputs are low, and oscEnable, battSwitchEnable and calibValue are 0.
- R2: A write to address 0x00 is stored and read back at 0x04 at once. The current time at 0x10 keeps counting from its old value until the next secPulse. At that pulse the current time becomes exactly the written value.
- R3: On a secPulse with no staged load waiting, the current time increases by one, wrapping from 0xFFFFFFFF to 0. Without a pulse it holds.
- R4: Status bit 0 (seconds) is set by every secPulse. Status bit 1 (alarm) is set by a secPulse whose resulting time equals the alarm value written at 0x18, whether that time comes from an increment or from a staged load.
- R5: Status is read at 0x20. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new event for the same bit fall in one cycle, the bit stays set.
- R6: Writing 1 to bit 0 or bit 1 at 0x28 enables the seconds or alarm source. Writing 1 to the same bit at 0x2C disables it. Address 0x24 reads back the enables, with 1 meaning enabled.
- R7: secIrq equals status bit 0 AND its enable, and alarmIrq equals status bit 1 AND its enable.
- R8: Address 0x40 holds two control bits, bit 24 (oscEnable) and bit 31 (battSwitchEnable). Both read back in place, and all other bits read 0.
- R9: A write to 0x08 keeps the low CALIB_W (21) bits. These bits drive calibValue and read back at 0x0C. Address 0x14 returns the tickCount input, zero-extended.
- R10: Unmapped addresses read 0. Writes to the read-only addresses 0x04, 0x0C, 0x10, 0x14 and 0x24 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secPulse | input | 1 | One-cycle pulse once per second from the timebase |
| tickCount | input | TICK_W | Fractional tick count from the tick generator |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| secIrq | output | 1 | Seconds interrupt |
| alarmIrq | output | 1 | Alarm interrupt |
| oscEnable | output | 1 | Oscillator enable control bit |
| battSwitchEnable | output | 1 | Battery switch-over enable control bit |
| calibValue | output | CALIB_W | Calibration word for the tick generator |

## Verification
The assertions assume that secPulse is a single-cycle strobe and that status only changes through a pulse or a write to the status address. Given that, they tie every counter movement to a pulse and classify each movement as either an increment or a staged load. The stimulus drives at most one register access per cycle and keeps pulses one cycle wide. It places pulses on purpose in the same cycle as a set-time write and as a status clear, and it steers the counter through the 32-bit wrap with the alarm parked at 0.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int N_IRQ  = 2;
  localparam int IRQ_SEC = 0;
  localparam int IRQ_ALM = 1;
  localparam int CTRL_OSC_BIT  = 24;
  localparam int CTRL_BATT_BIT = 31;

  localparam logic [ADDR_W-1:0] A_SET_WR  = 8'h00;
  localparam logic [ADDR_W-1:0] A_SET_RD  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CAL_WR  = 8'h08;
  localparam logic [ADDR_W-1:0] A_CAL_RD  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_TIME    = 8'h10;
  localparam logic [ADDR_W-1:0] A_TICK    = 8'h14;
  localparam logic [ADDR_W-1:0] A_ALARM   = 8'h18;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h20;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'h24;
  localparam logic [ADDR_W-1:0] A_IEN     = 8'h28;
  localparam logic [ADDR_W-1:0] A_IDIS    = 8'h2C;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h40;

  // load strobes from the control half to the datapath half
  typedef struct packed {
    logic ldSetTime;
    logic ldCalib;
    logic ldAlarm;
    logic ldCtrl;
  } regStrobe_t;
endpackage

// File: rtl/rtc_tk_ctrl.sv
module rtc_tk_ctrl
  import rtc_tk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic                   secEvt,
  input  logic                   alarmEvt,
  output regStrobe_t             strobes,
  output logic [N_IRQ-1:0]       status,
  output logic [N_IRQ-1:0]       enable,
  output logic                   secIrq,
  output logic                   alarmIrq
);
  logic [N_IRQ-1:0] evtMask;
  logic [N_IRQ-1:0] clrMask;
  logic [N_IRQ-1:0] enSetMask;
  logic [N_IRQ-1:0] enClrMask;

  always_comb begin
    strobes.ldSetTime = regWrEn && (regAddr == A_SET_WR);
    strobes.ldCalib   = regWrEn && (regAddr == A_CAL_WR);
    strobes.ldAlarm   = regWrEn && (regAddr == A_ALARM);
    strobes.ldCtrl    = regWrEn && (regAddr == A_CTRL);
  end

  always_comb begin
    evtMask          = '0;
    evtMask[IRQ_SEC] = secEvt;
    evtMask[IRQ_ALM] = alarmEvt;
    clrMask   = (regWrEn && regAddr == A_STATUS) ? regWrData[N_IRQ-1:0] : '0;
    enSetMask = (regWrEn && regAddr == A_IEN)    ? regWrData[N_IRQ-1:0] : '0;
    enClrMask = (regWrEn && regAddr == A_IDIS)   ? regWrData[N_IRQ-1:0] : '0;
  end

  // new event wins over a write-1 clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clrMask) | evtMask;
      enable <= (enable | enSetMask) & ~enClrMask;
    end
  end

  assign secIrq   = status[IRQ_SEC] & enable[IRQ_SEC];
  assign alarmIrq = status[IRQ_ALM] & enable[IRQ_ALM];
endmodule

// File: rtl/rtc_tk_datapath.sv
module rtc_tk_datapath
  import rtc_tk_pkg::*;
#(
  parameter int CALIB_W = 21,
  parameter int TICK_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   secPulse,
  input  logic [TICK_W-1:0]      tickCount,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  input  regStrobe_t             strobes,
  input  logic [N_IRQ-1:0]       status,
  input  logic [N_IRQ-1:0]       enable,
  output logic                   secEvt,
  output logic                   alarmEvt,
  output logic [DATA_W-1:0]      curTime,
  output logic [DATA_W-1:0]      stagedTime,
  output logic                   pending,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   oscEnable,
  output logic                   battSwitchEnable,
  output logic [CALIB_W-1:0]     calibValue
);
  localparam int CAL_PAD  = DATA_W - CALIB_W;
  localparam int TICK_PAD = DATA_W - TICK_W;
  localparam int IRQ_PAD  = DATA_W - N_IRQ;

  logic [DATA_W-1:0] alarmReg;
  logic [DATA_W-1:0] nextTime;
  logic [DATA_W-1:0] ctrlWord;

  assign nextTime = pending ? stagedTime : curTime + DATA_W'(1);
  assign secEvt   = secPulse;
  assign alarmEvt = secPulse && (nextTime == alarmReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime          <= '0;
      stagedTime       <= '0;
      pending          <= 1'b0;
      alarmReg         <= '0;
      calibValue       <= '0;
      oscEnable        <= 1'b0;
      battSwitchEnable <= 1'b0;
    end else begin
      if (secPulse) curTime <= nextTime;
      if (strobes.ldSetTime) begin
        stagedTime <= regWrData;
        pending    <= 1'b1;
      end else if (secPulse) begin
        pending    <= 1'b0;
      end
      if (strobes.ldAlarm) alarmReg   <= regWrData;
      if (strobes.ldCalib) calibValue <= regWrData[CALIB_W-1:0];
      if (strobes.ldCtrl) begin
        oscEnable        <= regWrData[CTRL_OSC_BIT];
        battSwitchEnable <= regWrData[CTRL_BATT_BIT];
      end
    end
  end

  always_comb begin
    ctrlWord                = '0;
    ctrlWord[CTRL_OSC_BIT]  = oscEnable;
    ctrlWord[CTRL_BATT_BIT] = battSwitchEnable;
  end

  always_comb begin
    case (regAddr)
      A_SET_RD: regRdData = stagedTime;
      A_CAL_RD: regRdData = {{CAL_PAD{1'b0}}, calibValue};
      A_TIME:   regRdData = curTime;
      A_TICK:   regRdData = {{TICK_PAD{1'b0}}, tickCount};
      A_ALARM:  regRdData = alarmReg;
      A_STATUS: regRdData = {{IRQ_PAD{1'b0}}, status};
      A_MASK:   regRdData = {{IRQ_PAD{1'b0}}, enable};
      A_CTRL:   regRdData = ctrlWord;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_tk_pkg::*;
#(
  parameter int CALIB_W = 21,
  parameter int TICK_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secPulse,
  input  logic [TICK_W-1:0]    tickCount,
  input  logic [7:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 secIrq,
  output logic                 alarmIrq,
  output logic                 oscEnable,
  output logic                 battSwitchEnable,
  output logic [CALIB_W-1:0]   calibValue
);
  regStrobe_t        strobes;
  logic [N_IRQ-1:0]  status;
  logic [N_IRQ-1:0]  enable;
  logic              secEvt;
  logic              alarmEvt;
  logic [DATA_W-1:0] curTime;
  logic [DATA_W-1:0] stagedTime;
  logic              pending;

  rtc_tk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .secEvt(secEvt), .alarmEvt(alarmEvt),
    .strobes(strobes), .status(status), .enable(enable),
    .secIrq(secIrq), .alarmIrq(alarmIrq)
  );

  rtc_tk_datapath #(.CALIB_W(CALIB_W), .TICK_W(TICK_W)) u_dp (
    .clk(clk), .rstN(rstN), .secPulse(secPulse), .tickCount(tickCount),
    .regAddr(regAddr), .regWrData(regWrData), .strobes(strobes),
    .status(status), .enable(enable), .secEvt(secEvt), .alarmEvt(alarmEvt),
    .curTime(curTime), .stagedTime(stagedTime), .pending(pending),
    .regRdData(regRdData), .oscEnable(oscEnable),
    .battSwitchEnable(battSwitchEnable), .calibValue(calibValue)
  );
endmodule

// File: rtl/rtc_tk_checker.sv
module rtc_tk_checker
  import rtc_tk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              secPulse,
  input logic              regWrEn,
  input logic [7:0]        regAddr,
  input logic [31:0]       curTime,
  input logic [31:0]       stagedTime,
  input logic              pending,
  input logic [1:0]        status,
  input logic [1:0]        enable,
  input logic              secIrq,
  input logic              alarmIrq
);
  logic stsWrite;
  assign stsWrite = regWrEn && (regAddr == A_STATUS);

  assert_time_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && !pending) |=> curTime == $past(curTime) + 32'd1);

  assert_time_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && pending) |=> curTime == $past(stagedTime));

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !secPulse |=> $stable(curTime));

  assert_sec_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> status[0]);

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!secPulse && !stsWrite) |=> $stable(status));

  assert_sec_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable[0] |-> !secIrq);

  assert_alarm_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !status[1] |-> !alarmIrq);
endmodule

bind rtc_timekeeper rtc_tk_checker u_chk (
  .clk(clk), .rstN(rstN), .secPulse(secPulse), .regWrEn(regWrEn),
  .regAddr(regAddr), .curTime(curTime), .stagedTime(stagedTime),
  .pending(pending), .status(status), .enable(enable),
  .secIrq(secIrq), .alarmIrq(alarmIrq)
);

// File: tb/rtc_timekeeper_bench.sv
`timescale 1ns/1ps
module rtc_timekeeper_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secPulse = 1'b0;
  logic [15:0] tickCount = 16'h0;
  logic [7:0]  regAddr = 8'h0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        secIrq, alarmIrq, oscEnable, battSwitchEnable;
  logic [20:0] calibValue;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] mTime = 0, mStaged = 0, mAlarm = 0;
  logic        mPend = 0, mOsc = 0, mBatt = 0;
  logic [20:0] mCal = 0;
  logic [1:0]  mSts = 0, mEn = 0;

  always #2.5 clk = ~clk;

  rtc_timekeeper u_rtc_timekeeper (
    .clk(clk), .rstN(rstN), .secPulse(secPulse), .tickCount(tickCount),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .secIrq(secIrq), .alarmIrq(alarmIrq),
    .oscEnable(oscEnable), .battSwitchEnable(battSwitchEnable),
    .calibValue(calibValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      8'h04: return mStaged;
      8'h0C: return {11'h0, mCal};
      8'h10: return mTime;
      8'h14: return {16'h0, tickCount};
      8'h18: return mAlarm;
      8'h20: return {30'h0, mSts};
      8'h24: return {30'h0, mEn};
      8'h40: return {mBatt, 6'h0, mOsc, 24'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmpOutputs();
    chk("R7 secIrq", {31'h0, secIrq}, {31'h0, mSts[0] & mEn[0]});
    chk("R7 alarmIrq", {31'h0, alarmIrq}, {31'h0, mSts[1] & mEn[1]});
    chk("R8 oscEnable", {31'h0, oscEnable}, {31'h0, mOsc});
    chk("R8 battSwitchEnable", {31'h0, battSwitchEnable}, {31'h0, mBatt});
    chk("R9 calibValue", {11'h0, calibValue}, {11'h0, mCal});
  endtask

  // one clock with optional pulse and optional write; reference updated alongside
  task automatic step(input logic p, input logic w, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] nT, nStaged, nAlarm;
    logic nPend, nOsc, nBatt, alEv;
    logic [20:0] nCal;
    logic [1:0] nSts, nEn, clr;
    @(negedge clk);
    secPulse = p; regWrEn = w; regAddr = a; regWrData = d;
    nT = p ? (mPend ? mStaged : mTime + 32'd1) : mTime;
    alEv = p && (nT == mAlarm);
    clr = (w && a == 8'h20) ? d[1:0] : 2'b00;
    nSts = (mSts & ~clr) | {alEv, p};
    nEn = mEn;
    if (w && a == 8'h28) nEn = nEn | d[1:0];
    if (w && a == 8'h2C) nEn = nEn & ~d[1:0];
    nStaged = mStaged; nPend = mPend;
    if (w && a == 8'h00) begin nStaged = d; nPend = 1; end
    else if (p) nPend = 0;
    nAlarm = (w && a == 8'h18) ? d : mAlarm;
    nCal = (w && a == 8'h08) ? d[20:0] : mCal;
    nOsc = (w && a == 8'h40) ? d[24] : mOsc;
    nBatt = (w && a == 8'h40) ? d[31] : mBatt;
    @(posedge clk);
    #1;
    mTime = nT; mStaged = nStaged; mPend = nPend; mAlarm = nAlarm;
    mCal = nCal; mOsc = nOsc; mBatt = nBatt; mSts = nSts; mEn = nEn;
    secPulse = 0; regWrEn = 0;
    cmpOutputs();
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    @(negedge clk);
    regAddr = a; regWrEn = 0; secPulse = 0;
    #1;
    chk(req, regRdData, mRead(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic pulse();
    step(1'b1, 1'b0, 8'h00, 32'h0);
  endtask

  initial begin
    #200us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    cmpOutputs();
    rd("R1 set-time readback", 8'h04);
    rd("R1 time", 8'h10);
    rd("R1 status", 8'h20);
    rd("R1 mask", 8'h24);
    rd("R1 ctrl", 8'h40);
    rd("R10 unmapped read", 8'h30);

    // R8 control bits
    wr(8'h40, 32'h8100_00FF);
    rd("R8 ctrl readback", 8'h40);
    chk("R8 literal ctrl", regRdData, 32'h8100_0000);
    wr(8'h40, 32'h0100_0000);
    rd("R8 ctrl osc only", 8'h40);

    // R9 calibration and tick
    wr(8'h08, 32'hFFFF_FFFF);
    rd("R9 calib readback", 8'h0C);
    chk("R9 literal calib", regRdData, 32'h001F_FFFF);
    tickCount = 16'hBEEF;
    rd("R9 tick readback", 8'h14);

    // R6 enables
    wr(8'h28, 32'h3);
    rd("R6 mask both", 8'h24);

    // R2 staged set-time
    wr(8'h00, 32'd100);
    rd("R2 set-time readback", 8'h04);
    rd("R2 time not yet loaded", 8'h10);
    chk("R2 literal old time", regRdData, 32'd0);
    pulse();
    rd("R2 time after load", 8'h10);
    chk("R2 literal loaded", regRdData, 32'd100);
    pulse();
    pulse();
    rd("R3 increment", 8'h10);
    chk("R3 literal 102", regRdData, 32'd102);

    // R5 status write-1-clear
    rd("R4 seconds status", 8'h20);
    wr(8'h20, 32'h0);
    rd("R5 write zero keeps", 8'h20);
    wr(8'h20, 32'h1);
    rd("R5 write one clears", 8'h20);
    step(1'b1, 1'b1, 8'h20, 32'h1);
    rd("R5 event wins over clear", 8'h20);

    // R4 alarm by increment
    wr(8'h18, 32'd106);
    pulse(); pulse();
    rd("R4 alarm not yet", 8'h20);
    pulse();
    rd("R4 alarm hit", 8'h20);
    chk("R4 literal status", regRdData, 32'h3);
    wr(8'h2C, 32'h2);
    rd("R6 alarm disabled mask", 8'h24);
    wr(8'h28, 32'h2);
    wr(8'h20, 32'h3);
    rd("R5 cleared both", 8'h20);

    // R4 alarm through a staged load and R3 wrap
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    pulse();
    rd("R4 alarm via load", 8'h20);
    wr(8'h20, 32'h3);
    wr(8'h18, 32'h0);
    pulse();
    rd("R3 wrap to zero", 8'h10);
    rd("R4 alarm at wrap", 8'h20);

    // R2 set-time write coinciding with a pulse
    step(1'b1, 1'b1, 8'h00, 32'd500);
    rd("R2 same-cycle write not loaded", 8'h10);
    pulse();
    rd("R2 same-cycle write loads next", 8'h10);

    // R10 read-only writes ignored
    wr(8'h10, 32'd7);
    wr(8'h24, 32'h0);
    wr(8'h0C, 32'h5);
    wr(8'h04, 32'h9);
    rd("R10 time untouched", 8'h10);
    rd("R10 mask untouched", 8'h24);
    rd("R10 calib untouched", 8'h0C);
    rd("R10 set readback untouched", 8'h04);
    pulse();
    rd("R10 no spurious load", 8'h10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule